// File: doc/BRIEF.md
# Partitionable SIMD Integer Multiplier

This block multiplies two 64-bit unsigned operands using an array of sixteen 16×16 subblock multipliers. Each subblock multiplies one 16-bit chunk of operand A by one 16-bit chunk of operand B. A shared adder network then weights and sums the subblock results according to the selected mode. A 2-bit mode input picks the operation:

- one full-width multiply;
- two independent 32-bit multiplies, one in each half of the operands;
- four independent 16-bit multiplies, one in each 16-bit lane.

Every result is truncated to the width of its lane and packed into a single 64-bit output word.

A subblock is enabled only when its partial product can reach a kept result bit in the current mode and an operation is being issued. A disabled subblock keeps its last registered value, so it does not toggle. The unit is fully pipelined. It accepts one operation per clock and returns each result two cycles later with a matching valid flag.

Top module: `split_mul64`

## Requirements
- R1: With mode 2'b00, product equals the low 64 bits of op_a × op_b.
- R2: With mode 2'b01, product[31:0] is the low 32 bits of op_a[31:0] × op_b[31:0], and product[63:32] is the low 32 bits of op_a[63:32] × op_b[63:32].
- R3: With mode 2'b10, product[16k+15:16k] is the low 16 bits of op_a[16k+15:16k] × op_b[16k+15:16k], for k = 0..3.
- R4: Mode 2'b11 is reserved. It produces a product of zero and its valid flag still propagates.
- R5: out_valid is asserted exactly two clock edges after the edge that samples in_valid high. Operations can be issued on consecutive cycles with no gaps.
- R6: tile_en bit 4i+j enables the subblock that multiplies A chunk i by B chunk j. When in_valid is high, tile_en is:
  - 16'h137F in mode 2'b00 (i+j ≤ 3);
  - 16'h4C13 in mode 2'b01;
  - 16'h8421 in mode 2'b10;
  - 16'h0000 in mode 2'b11.
  When in_valid is low, tile_en is 16'h0000.
- R7: While out_valid is low, product holds the last valid result.
- R8: After reset, out_valid is 0 and product is 0.
- R9: Each result depends only on its own operands and mode. A result is correct right after a change of mode, even though disabled subblocks still hold results from earlier operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Issue strobe for the operands and mode on this cycle |
| mode | input | 2 | 00 = 64-bit, 01 = two 32-bit, 10 = four 16-bit, 11 = reserved |
| op_a | input | 64 | Multiplicand |
| op_b | input | 64 | Multiplier |
| out_valid | output | 1 | product carries a new result |
| product | output | 64 | Packed result(s) |
| tile_en | output | 16 | Per-subblock enable, bit 4i+j for A chunk i and B chunk j |

## Verification
A wrong weight or a missing subblock in the adder network shows up as a wrong product exactly two cycles after the operation is issued. A stale partial product leaking from a gated subblock shows up on the first operation after a mode change. Both are caught by streaming back-to-back operations with a random mode on every cycle, together with edge-value operands such as all-ones and lane MSBs. An error in the enable mask is visible on tile_en in the same cycle as the issue. A broken valid pipeline shows up as out_valid misaligned with the two-cycle schedule, or as product changing while out_valid is low.

// File: rtl/mulp_pkg.sv
package mulp_pkg;

    typedef enum logic [1:0] {
        MODE_W64 = 2'b00,
        MODE_W32 = 2'b01,
        MODE_W16 = 2'b10,
        MODE_RSV = 2'b11
    } mul_mode_e;

    // Whether subblock (A chunk i, B chunk j) can reach a kept result bit.
    function automatic logic tile_used(input mul_mode_e m, input int i, input int j,
                                       input int grid);
        int half;
        half = grid / 2;
        case (m)
            MODE_W64: return (i + j) < grid;
            MODE_W32: return ((i / half) == (j / half)) && (((i % half) + (j % half)) < half);
            MODE_W16: return i == j;
            default:  return 1'b0;
        endcase
    endfunction

    // Weight of a subblock's partial product, in chunks, inside its lane.
    function automatic int tile_shift(input mul_mode_e m, input int i, input int j,
                                      input int grid);
        int half;
        half = grid / 2;
        case (m)
            MODE_W64: return i + j;
            MODE_W32: return (i % half) + (j % half);
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/mulp_tile.sv
module mulp_tile #(
    parameter int SW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [SW-1:0]   a,
    input  logic [SW-1:0]   b,
    output logic [2*SW-1:0] pp
);
    localparam int PW = 2 * SW;

    logic [PW-1:0] pp_d, pp_q;

    always_comb begin
        pp_d = pp_q;
        if (en) begin
            pp_d = a * b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign pp = pp_q;
endmodule

// File: rtl/mulp_combine.sv
module mulp_combine
    import mulp_pkg::*;
#(
    parameter int SW   = 16,
    parameter int GRID = 4
) (
    input  mul_mode_e                    mode,
    input  logic [GRID*GRID*2*SW-1:0]    pp_flat,
    output logic [SW*GRID-1:0]           res
);
    localparam int W    = SW * GRID;
    localparam int HW   = W / 2;
    localparam int PW   = 2 * SW;
    localparam int HALF = GRID / 2;

    logic [W-1:0]  acc_full;
    logic [HW-1:0] acc_lo, acc_hi;
    logic [W-1:0]  diag;
    logic [PW-1:0] tv;
    logic [W-1:0]  wide;

    always_comb begin
        acc_full = '0;
        acc_lo   = '0;
        acc_hi   = '0;
        diag     = '0;
        tv       = '0;
        wide     = '0;
        for (int i = 0; i < GRID; i++) begin
            for (int j = 0; j < GRID; j++) begin
                tv   = pp_flat[(i*GRID+j)*PW +: PW];
                wide = W'(tv) << (SW * tile_shift(mode, i, j, GRID));
                if (tile_used(mode, i, j, GRID)) begin
                    if (mode == MODE_W64) begin
                        acc_full = acc_full + wide;
                    end else if (mode == MODE_W32) begin
                        if (i < HALF) acc_lo = acc_lo + wide[HW-1:0];
                        else          acc_hi = acc_hi + wide[HW-1:0];
                    end else if (mode == MODE_W16) begin
                        diag[i*SW +: SW] = tv[SW-1:0];
                    end
                end
            end
        end
        case (mode)
            MODE_W64: res = acc_full;
            MODE_W32: res = {acc_hi, acc_lo};
            MODE_W16: res = diag;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/split_mul64.sv
module split_mul64
    import mulp_pkg::*;
#(
    parameter int SUB_W = 16,
    parameter int GRID  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             mode,
    input  logic [SUB_W*GRID-1:0]  op_a,
    input  logic [SUB_W*GRID-1:0]  op_b,
    output logic                   out_valid,
    output logic [SUB_W*GRID-1:0]  product,
    output logic [GRID*GRID-1:0]   tile_en
);
    localparam int W  = SUB_W * GRID;
    localparam int NT = GRID * GRID;
    localparam int PW = 2 * SUB_W;

    typedef struct packed {
        logic      v1;
        mul_mode_e m1;
        logic      v2;
        logic [W-1:0] res;
    } pipe_t;

    pipe_t st_d, st_q;
    mul_mode_e mode_e;
    logic [NT*PW-1:0] pp_flat;
    logic [W-1:0] comb_res;

    assign mode_e = mul_mode_e'(mode);

    always_comb begin
        for (int i = 0; i < GRID; i++) begin
            for (int j = 0; j < GRID; j++) begin
                tile_en[i*GRID+j] = in_valid && tile_used(mode_e, i, j, GRID);
            end
        end
    end

    for (genvar gi = 0; gi < GRID; gi++) begin : g_row
        for (genvar gj = 0; gj < GRID; gj++) begin : g_col
            mulp_tile #(.SW(SUB_W)) u_tile (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (tile_en[gi*GRID+gj]),
                .a     (op_a[gi*SUB_W +: SUB_W]),
                .b     (op_b[gj*SUB_W +: SUB_W]),
                .pp    (pp_flat[(gi*GRID+gj)*PW +: PW])
            );
        end
    end

    mulp_combine #(.SW(SUB_W), .GRID(GRID)) u_comb (
        .mode    (st_q.m1),
        .pp_flat (pp_flat),
        .res     (comb_res)
    );

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.m1 = mode_e;
        end
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.res = comb_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.v2;
    assign product   = st_q.res;
endmodule

// File: rtl/split_mul64_chk.sv
module split_mul64_chk #(
    parameter int SUB_W = 16,
    parameter int GRID  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [1:0]             mode,
    input logic [SUB_W*GRID-1:0]  op_a,
    input logic [SUB_W*GRID-1:0]  op_b,
    input logic                   out_valid,
    input logic [SUB_W*GRID-1:0]  product,
    input logic [GRID*GRID-1:0]   tile_en
);
    localparam int HALF = GRID / 2;
    localparam int C64  = GRID * (GRID + 1) / 2;
    localparam int C32  = HALF * (HALF + 1);
    localparam int C16  = GRID;

    logic [1:0] since_rst;
    logic [2*SUB_W-1:0] lane0_full;

    assign lane0_full = op_a[SUB_W-1:0] * op_b[SUB_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    p_valid_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst == 2'd2) |-> $past(in_valid, 2));

    p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (tile_en == '0));

    p_count64_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00) |-> ($countones(tile_en) == C64));

    p_count32_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01) |-> ($countones(tile_en) == C32));

    p_count16_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b10) |-> ($countones(tile_en) == C16));

    p_rsv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst == 2'd2 && $past(mode, 2) == 2'b11) |-> (product == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && since_rst != 2'd0) |-> $stable(product));

    p_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst == 2'd2 && $past(mode, 2) == 2'b10)
        |-> (product[SUB_W-1:0] == $past(lane0_full[SUB_W-1:0], 2)));
endmodule

bind split_mul64 split_mul64_chk #(.SUB_W(SUB_W), .GRID(GRID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product),
    .tile_en   (tile_en)
);

// File: tb/split_mul64_test.sv
module split_mul64_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [63:0] product;
    logic [15:0] tile_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // expected pipeline: stage 1 = issued last negedge, stage 2 = the one before
    logic        q1_v = 1'b0, q2_v = 1'b0;
    logic [63:0] q1_p = '0, q2_p = '0, last_p = '0;
    string       q1_t = "R8", q2_t = "R8";
    logic [1:0]  prev_mode = 2'b00;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    split_mul64 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .product(product), .tile_en(tile_en)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] expected(input logic [1:0] m, input logic [63:0] x,
                                             input logic [63:0] y);
        logic [63:0] r;
        r = '0;
        case (m)
            2'b00: r = x * y;
            2'b01: begin
                r[31:0]  = x[31:0] * y[31:0];
                r[63:32] = x[63:32] * y[63:32];
            end
            2'b10: begin
                r[15:0]  = x[15:0]  * y[15:0];
                r[31:16] = x[31:16] * y[31:16];
                r[47:32] = x[47:32] * y[47:32];
                r[63:48] = x[63:48] * y[63:48];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] mask_for(input logic [1:0] m);
        case (m)
            2'b00:   return 16'h137F;
            2'b01:   return 16'h4C13;
            2'b10:   return 16'h8421;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [63:0] special(input int k);
        case (k)
            0:       return 64'h0;
            1:       return 64'hFFFF_FFFF_FFFF_FFFF;
            2:       return 64'h1;
            3:       return 64'h8000_8000_8000_8000;
            4:       return 64'hFFFF_0000_FFFF_0000;
            5:       return 64'h5555_AAAA_5555_AAAA;
            6:       return 64'h0001_0000_0000_0001;
            default: return 64'h7FFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] m, input logic [1:0] pm);
        if (m != pm) return "R9";
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic step(input logic v, input logic [1:0] m, input logic [63:0] x,
                        input logic [63:0] y);
        @(negedge clk);
        // result of the op issued two negedges ago (R5 timing)
        check("R5", {63'd0, out_valid}, {63'd0, q2_v});
        if (q2_v) begin
            check(q2_t, product, q2_p);
            last_p = q2_p;
        end else begin
            check("R7", product, last_p);
        end
        q2_v = q1_v; q2_p = q1_p; q2_t = q1_t;
        q1_v = v;
        q1_p = expected(m, x, y);
        q1_t = tag_for(m, prev_mode);
        if (v) prev_mode = m;
        in_valid = v; mode = m; op_a = x; op_b = y;
        #1;
        check("R6", {48'd0, tile_en}, {48'd0, (v ? mask_for(m) : 16'h0000)});
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", {63'd0, out_valid}, 64'd0);
        check("R8", product, 64'd0);

        // directed edge-value sweep, back to back, all modes
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    step(1'b1, 2'(m), special(i), special(j));
                end
            end
        end
        step(1'b0, 2'b00, 64'hDEAD_BEEF_0000_1111, 64'h1234);
        step(1'b0, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);

        // random stream: random mode each cycle, some idle cycles
        for (int n = 0; n < 1500; n++) begin
            logic [63:0] x, y;
            lfsr = next_rand(lfsr); x = lfsr;
            lfsr = next_rand(lfsr); y = lfsr;
            lfsr = next_rand(lfsr);
            step(lfsr[7:5] != 3'b000, lfsr[1:0], x, y);
        end

        for (int n = 0; n < 3; n++) begin
            step(1'b0, 2'b00, 64'h0, 64'h0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule